// File: doc/BRIEF.md
# Exception Entry Machine State Unit

This unit keeps the 32-bit machine state word of a small RISC core and performs the state changes around exceptions. When an exception is taken, the pre-exception word, minus a few reserved bits, is copied into a companion save word. In the live word, the bits that would let a handler be interrupted or trapped are cleared, and the byte order for the handler is taken from a dedicated handler-byte-order bit. A return-from-interrupt strobe copies the save word back into the live word.

Bits are numbered 0 (most significant) to 31, which is vector index 31−n. Field positions (bit number): power manage 13, handler byte order 15, interrupt enable 16, user mode 17, FP available 18, machine-check enable 19, FP mode A 20, step trace 21, branch trace 22, FP mode B 23, vector prefix 25, instruction translate 26, data translate 27, perf mark 29, recoverable 30, byte order 31.

The core presents exception requests, a retire strobe with an instruction class, FP and supervisor-only flags, a return strobe and a move-to write port. It receives a one-hot acknowledge, a sticky checkstop, fault indications and the qualifier bits of the live word.

Top module: `exc_state_unit`

## Requirements
- R1: Synchronous reset (`rst`=1) sets the live word to 32'h0000_1000 (only machine-check enable, bit 19, set), the save word to zero and `checkstop` to 0.
- R2: On exception entry the save word receives the pre-entry live word with bits 1:4 and 10:12 forced to zero, i.e. live & 32'h87C7_FFFF.
- R3: On exception entry the live word clears bits 16, 17, 18, 21, 26 and 27, copies bit 15 into bit 31, and keeps every other bit.
- R4: External (`extReq`) and decrementer (`decReq`) requests are acknowledged only while bit 16 is 1; otherwise they are held unacknowledged and the state is unchanged.
- R5: At most one acknowledge is raised per cycle, with priority machine check, then trace, then external, then decrementer. An acknowledge starts exception entry at that clock edge.
- R6: A machine-check request while bit 19 is 0 raises no acknowledge and sets `checkstop` at the next edge. `checkstop` stays 1 until reset, and no acknowledge is raised while it is 1.
- R7: While bit 21 is 1, a retiring instruction of class 0 (plain) that raises neither `fpUnavail` nor `privViol` requests a trace. Classes 1 (return), 2 (sync) and 3 (system call) never do.
- R8: `fpUnavail` is 1 when a retiring instruction has `retireFp`=1 while bit 18 is 0.
- R9: `privViol` is 1 when a retiring instruction has `retireSuper`=1 while bit 17 is 1.
- R10: `rfiStrobe` loads the live word from the save word at the next edge. No acknowledge is raised in that cycle, so pending requests are evaluated again on the following cycle.
- R11: `mtWrEn` writes `mtWrData` to the live word (`mtSel`=0) or to the save word (`mtSel`=1). The write is dropped in a cycle with exception entry or return.
- R12: `intEnable`, `userMode`, `fpAvail`, `mcEnable` and `traceEnable` show live bits 16, 17, 18, 19 and 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mcReq | input | 1 | Machine-check request |
| extReq | input | 1 | External interrupt request |
| decReq | input | 1 | Decrementer request |
| retireValid | input | 1 | An instruction retires this cycle |
| retireClass | input | 2 | 0 plain, 1 return, 2 sync, 3 system call |
| retireFp | input | 1 | Retiring instruction is a floating-point one |
| retireSuper | input | 1 | Retiring instruction is supervisor-only |
| rfiStrobe | input | 1 | Return from interrupt |
| mtWrEn | input | 1 | Move-to write enable |
| mtSel | input | 1 | 0 live word, 1 save word |
| mtWrData | input | 32 | Move-to write data |
| stateOut | output | 32 | Live machine state word |
| saveOut | output | 32 | Save word |
| ackMc | output | 1 | Machine check taken |
| ackTrace | output | 1 | Trace taken |
| ackExt | output | 1 | External interrupt taken |
| ackDec | output | 1 | Decrementer taken |
| checkstop | output | 1 | Sticky checkstop |
| fpUnavail | output | 1 | FP instruction while FP unavailable |
| privViol | output | 1 | Supervisor-only instruction in user mode |
| intEnable | output | 1 | Live bit 16 |
| userMode | output | 1 | Live bit 17 |
| fpAvail | output | 1 | Live bit 18 |
| mcEnable | output | 1 | Live bit 19 |
| traceEnable | output | 1 | Live bit 21 |

## Verification
The assertions assume that requests are levels the source holds until they are acknowledged, and that a return strobe and a move-to write are never needed in the same cycle as a wanted acknowledge. They also assume that every input is settled before the clock edge. The bench changes inputs only on the falling edge and samples the combinational acknowledges in the middle of the low phase. Where it must look at several request mixes without starting an entry, it withdraws the requests before the rising edge.

// File: rtl/exc_state_pkg.sv
`timescale 1ns/100ps
package exc_state_pkg;
  localparam int StateW = 32;

  // bit numbers count from the MSB; convert to vector index
  function automatic int pos(input int n);
    return StateW - 1 - n;
  endfunction

  localparam int HandlerLeBit = pos(15);
  localparam int IntEnBit     = pos(16);
  localparam int UserBit      = pos(17);
  localparam int FpAvBit      = pos(18);
  localparam int McEnBit      = pos(19);
  localparam int StepBit      = pos(21);
  localparam int IxlBit       = pos(26);
  localparam int DxlBit       = pos(27);
  localparam int LeBit        = pos(31);

  function automatic logic [StateW-1:0] rangeMask(input int lo, input int hi);
    logic [StateW-1:0] m;
    m = '0;
    for (int n = lo; n <= hi; n++) m[pos(n)] = 1'b1;
    return m;
  endfunction

  // reserved bits not carried into the save word
  localparam logic [StateW-1:0] DropMask = rangeMask(1, 4) | rangeMask(10, 12);
  // bits cleared in the live word on entry
  localparam logic [StateW-1:0] ClearMask =
    (StateW'(1) << IntEnBit) | (StateW'(1) << UserBit) | (StateW'(1) << FpAvBit) |
    (StateW'(1) << StepBit)  | (StateW'(1) << IxlBit)  | (StateW'(1) << DxlBit);
  localparam logic [StateW-1:0] ResetLive = StateW'(1) << McEnBit;

  typedef enum logic [1:0] {ClsPlain = 2'd0, ClsRet = 2'd1, ClsSync = 2'd2, ClsSysCall = 2'd3} instClass_e;

  typedef struct packed {
    logic enter;
    logic restore;
    logic wrLive;
    logic wrSave;
  } dpCtl_t;
endpackage

// File: rtl/exc_state_ctrl.sv
`timescale 1ns/100ps
module exc_state_ctrl
  import exc_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mcReq,
  input  logic       extReq,
  input  logic       decReq,
  input  logic       retireValid,
  input  logic [1:0] retireClass,
  input  logic       retireFp,
  input  logic       retireSuper,
  input  logic       rfiStrobe,
  input  logic       mtWrEn,
  input  logic       mtSel,
  input  logic       intEn,
  input  logic       userMode,
  input  logic       fpAv,
  input  logic       mcEn,
  input  logic       stepEn,
  output dpCtl_t     ctl,
  output logic       ackMc,
  output logic       ackTrace,
  output logic       ackExt,
  output logic       ackDec,
  output logic       checkstop,
  output logic       fpUnavail,
  output logic       privViol
);
  logic stopQ, blocked, traceReq, mcFatal, anyAck;

  always_comb begin
    fpUnavail = retireValid & retireFp & ~fpAv;
    privViol  = retireValid & retireSuper & userMode;
    traceReq  = retireValid & stepEn & (retireClass == ClsPlain) & ~fpUnavail & ~privViol;
    blocked   = stopQ | rfiStrobe;
    mcFatal   = mcReq & ~mcEn;
    ackMc     = ~blocked & mcReq & mcEn;
    ackTrace  = ~blocked & ~mcReq & traceReq;
    ackExt    = ~blocked & ~mcReq & ~traceReq & intEn & extReq;
    ackDec    = ~blocked & ~mcReq & ~traceReq & intEn & ~extReq & decReq;
    anyAck    = ackMc | ackTrace | ackExt | ackDec;
    ctl.enter   = anyAck;
    ctl.restore = rfiStrobe;
    ctl.wrLive  = mtWrEn & ~mtSel & ~anyAck & ~rfiStrobe;
    ctl.wrSave  = mtWrEn & mtSel & ~anyAck & ~rfiStrobe;
  end

  always_ff @(posedge clk) begin
    if (rst)          stopQ <= 1'b0;
    else if (mcFatal) stopQ <= 1'b1;
  end
  assign checkstop = stopQ;

  p_one_ack_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ackMc, ackTrace, ackExt, ackDec}));
  p_ext_gated_r4: assert property (@(posedge clk) disable iff (rst)
    !intEn |-> !(ackExt || ackDec));
  p_stop_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    checkstop |=> checkstop);
  p_stop_no_ack_r6: assert property (@(posedge clk) disable iff (rst)
    checkstop |-> !(ackMc || ackTrace || ackExt || ackDec));
  p_rfi_no_ack_r10: assert property (@(posedge clk) disable iff (rst)
    rfiStrobe |-> !ctl.enter);
endmodule

// File: rtl/exc_state_dp.sv
`timescale 1ns/100ps
module exc_state_dp
  import exc_state_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [StateW-1:0] wrData,
  output logic [StateW-1:0] liveQ,
  output logic [StateW-1:0] saveQ
);
  logic [StateW-1:0] entryLive;

  always_comb begin
    entryLive = liveQ & ~ClearMask;
    entryLive[LeBit] = liveQ[HandlerLeBit];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      liveQ <= ResetLive;
      saveQ <= '0;
    end else if (ctl.enter) begin
      saveQ <= liveQ & ~DropMask;
      liveQ <= entryLive;
    end else if (ctl.restore) begin
      liveQ <= saveQ;
    end else begin
      if (ctl.wrLive) liveQ <= wrData;
      if (ctl.wrSave) saveQ <= wrData;
    end
  end

  p_entry_drop_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.enter |=> ((saveQ & DropMask) == '0));
  p_entry_clear_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.enter |=> ((liveQ & ClearMask) == '0));
  p_entry_le_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.enter |=> (liveQ[LeBit] == $past(liveQ[HandlerLeBit])));
  p_rfi_restore_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl.restore && !ctl.enter) |=> (liveQ == $past(saveQ)));
endmodule

// File: rtl/exc_state_unit.sv
`timescale 1ns/100ps
module exc_state_unit
  import exc_state_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        mcReq,
  input  logic        extReq,
  input  logic        decReq,
  input  logic        retireValid,
  input  logic [1:0]  retireClass,
  input  logic        retireFp,
  input  logic        retireSuper,
  input  logic        rfiStrobe,
  input  logic        mtWrEn,
  input  logic        mtSel,
  input  logic [31:0] mtWrData,
  output logic [31:0] stateOut,
  output logic [31:0] saveOut,
  output logic        ackMc,
  output logic        ackTrace,
  output logic        ackExt,
  output logic        ackDec,
  output logic        checkstop,
  output logic        fpUnavail,
  output logic        privViol,
  output logic        intEnable,
  output logic        userMode,
  output logic        fpAvail,
  output logic        mcEnable,
  output logic        traceEnable
);
  dpCtl_t ctl;
  logic [StateW-1:0] liveQ, saveQ;

  assign intEnable   = liveQ[IntEnBit];
  assign userMode    = liveQ[UserBit];
  assign fpAvail     = liveQ[FpAvBit];
  assign mcEnable    = liveQ[McEnBit];
  assign traceEnable = liveQ[StepBit];
  assign stateOut    = liveQ;
  assign saveOut     = saveQ;

  exc_state_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mcReq(mcReq), .extReq(extReq), .decReq(decReq),
    .retireValid(retireValid), .retireClass(retireClass), .retireFp(retireFp),
    .retireSuper(retireSuper), .rfiStrobe(rfiStrobe), .mtWrEn(mtWrEn), .mtSel(mtSel),
    .intEn(intEnable), .userMode(userMode), .fpAv(fpAvail), .mcEn(mcEnable),
    .stepEn(traceEnable), .ctl(ctl), .ackMc(ackMc), .ackTrace(ackTrace),
    .ackExt(ackExt), .ackDec(ackDec), .checkstop(checkstop),
    .fpUnavail(fpUnavail), .privViol(privViol)
  );

  exc_state_dp u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .wrData(mtWrData),
    .liveQ(liveQ), .saveQ(saveQ)
  );
endmodule

// File: tb/exc_state_unit_tb.sv
`timescale 1ns/100ps
module exc_state_unit_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic mcReq = 0, extReq = 0, decReq = 0, retireValid = 0, retireFp = 0, retireSuper = 0;
  logic rfiStrobe = 0, mtWrEn = 0, mtSel = 0;
  logic [1:0] retireClass = 2'd0;
  logic [31:0] mtWrData = '0;
  logic [31:0] stateOut, saveOut;
  logic ackMc, ackTrace, ackExt, ackDec, checkstop, fpUnavail, privViol;
  logic intEnable, userMode, fpAvail, mcEnable, traceEnable;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_state_unit u_dut (.*);

  function automatic logic [31:0] bm(input int n);
    return 32'd1 << (31 - n);
  endfunction

  function automatic logic [31:0] saveExp(input logic [31:0] v);
    logic [31:0] d = '0;
    for (int n = 1; n <= 4; n++) d |= bm(n);
    for (int n = 10; n <= 12; n++) d |= bm(n);
    return v & ~d;
  endfunction

  function automatic logic [31:0] liveExp(input logic [31:0] v);
    logic [31:0] c = bm(16) | bm(17) | bm(18) | bm(21) | bm(26) | bm(27) | bm(31);
    return (v & ~c) | (((v & bm(15)) != 0) ? bm(31) : 32'd0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clearIn();
    mcReq = 0; extReq = 0; decReq = 0; retireValid = 0; retireFp = 0; retireSuper = 0;
    retireClass = 0; rfiStrobe = 0; mtWrEn = 0; mtSel = 0;
  endtask

  task automatic setLive(input logic [31:0] v);
    mtWrEn = 1; mtSel = 0; mtWrData = v; tick(); mtWrEn = 0;
  endtask

  task automatic t_reset();
    chk("R1 live", stateOut, 32'h0000_1000);
    chk("R1 save", saveOut, 32'h0);
    chk("R1 checkstop", {31'd0, checkstop}, 32'd0);
    chk("R12 mcEnable", {31'd0, mcEnable}, 32'd1);
    chk("R12 intEnable", {31'd0, intEnable}, 32'd0);
  endtask

  task automatic t_write();
    setLive(32'hFFFF_FFFF);
    chk("R11 live write", stateOut, 32'hFFFF_FFFF);
    chk("R12 qualifiers", {27'd0, intEnable, userMode, fpAvail, mcEnable, traceEnable}, 32'h1F);
    mtWrEn = 1; mtSel = 1; mtWrData = 32'h1234_5678; tick(); mtWrEn = 0;
    chk("R11 save write", saveOut, 32'h1234_5678);
    chk("R11 live kept", stateOut, 32'hFFFF_FFFF);
  endtask

  task automatic t_extEntry();
    logic [31:0] v = 32'hFFFF_FFFF;
    logic [31:0] after;
    setLive(v);
    extReq = 1; #1;
    chk("R4 ext ack", {31'd0, ackExt}, 32'd1);
    @(negedge clk);
    chk("R2 save on entry", saveOut, saveExp(v));
    chk("R3 live on entry", stateOut, liveExp(v));
    after = stateOut;
    #1;
    chk("R4 ext held", {31'd0, ackExt}, 32'd0);
    tick();
    chk("R4 state unchanged", stateOut, after);
    extReq = 0;
    // LE from handler-order bit 15 = 0
    v = bm(16) | bm(19) | bm(31) | bm(3) | bm(5);
    setLive(v);
    decReq = 1; #1;
    chk("R5 dec ack", {31'd0, ackDec}, 32'd1);
    @(negedge clk); decReq = 0;
    chk("R3 LE cleared", stateOut, liveExp(v));
    chk("R2 reserved dropped", saveOut, saveExp(v));
  endtask

  task automatic t_priority();
    setLive(bm(16) | bm(19) | bm(21));
    mcReq = 1; extReq = 1; decReq = 1; retireValid = 1; #1;
    chk("R5 mc first", {28'd0, ackMc, ackTrace, ackExt, ackDec}, 32'b1000);
    mcReq = 0; #0.2;
    chk("R5 trace second", {28'd0, ackMc, ackTrace, ackExt, ackDec}, 32'b0100);
    retireValid = 0; #0.2;
    chk("R5 ext third", {28'd0, ackMc, ackTrace, ackExt, ackDec}, 32'b0010);
    extReq = 0; #0.2;
    chk("R5 dec last", {28'd0, ackMc, ackTrace, ackExt, ackDec}, 32'b0001);
    clearIn(); @(negedge clk);
  endtask

  task automatic t_trace();
    setLive(bm(19) | bm(21));
    retireValid = 1;
    for (int c = 1; c < 4; c++) begin
      retireClass = 2'(c); #0.3;
      chk("R7 excluded class", {31'd0, ackTrace}, 32'd0);
    end
    retireClass = 0; #0.3;
    chk("R7 plain traced", {31'd0, ackTrace}, 32'd1);
    retireFp = 1; #0.3;
    chk("R8 fp unavailable", {31'd0, fpUnavail}, 32'd1);
    chk("R7 no trace on fault", {31'd0, ackTrace}, 32'd0);
    clearIn(); @(negedge clk);
    setLive(bm(18) | bm(19));
    retireValid = 1; retireFp = 1; #1;
    chk("R8 fp available", {31'd0, fpUnavail}, 32'd0);
    clearIn(); @(negedge clk);
  endtask

  task automatic t_priv();
    setLive(bm(17) | bm(19));
    retireValid = 1; retireSuper = 1; #1;
    chk("R9 user violation", {31'd0, privViol}, 32'd1);
    clearIn(); @(negedge clk);
    setLive(bm(19));
    retireValid = 1; retireSuper = 1; #1;
    chk("R9 supervisor ok", {31'd0, privViol}, 32'd0);
    clearIn(); @(negedge clk);
  endtask

  task automatic t_rfi();
    logic [31:0] v = bm(15) | bm(16) | bm(19);
    logic [31:0] entered;
    setLive(v);
    extReq = 1; tick(); extReq = 0;
    chk("R3 LE from handler bit", stateOut, bm(15) | bm(19) | bm(31));
    entered = stateOut;
    // entry beats move-to write
    setLive(v);
    extReq = 1; mtWrEn = 1; mtSel = 0; mtWrData = 32'hAAAA_5555; tick();
    clearIn();
    chk("R11 entry wins", stateOut, entered);
    rfiStrobe = 1; mcReq = 1; extReq = 1; #1;
    chk("R10 no ack in rfi", {28'd0, ackMc, ackTrace, ackExt, ackDec}, 32'd0);
    #0.5; mcReq = 0;
    @(negedge clk); rfiStrobe = 0;
    chk("R10 restored", stateOut, v);
    #1;
    chk("R10 ext after return", {31'd0, ackExt}, 32'd1);
    @(negedge clk); clearIn();
  endtask

  task automatic t_stop();
    setLive(bm(16));
    mcReq = 1; #1;
    chk("R6 no ack ME=0", {31'd0, ackMc}, 32'd0);
    @(negedge clk); mcReq = 0;
    chk("R6 checkstop set", {31'd0, checkstop}, 32'd1);
    tick();
    chk("R6 checkstop sticky", {31'd0, checkstop}, 32'd1);
    extReq = 1; #1;
    chk("R6 acks blocked", {31'd0, ackExt}, 32'd0);
    @(negedge clk); clearIn();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #40000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    finishRun();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    t_reset();
    t_write();
    t_extEntry();
    t_priority();
    t_trace();
    t_priv();
    t_rfi();
    t_stop();
    finishRun();
  end
endmodule